// File: doc/BRIEF.md
# Programmable Memory Pattern Sequencer

This block runs a small microprogram for each external memory transaction. A 64-word pattern store holds the microcode. Whenever the sequencer is idle, it accepts one request. The request can be a single-beat or burst memory read or write, a periodic refresh tick, an exception event, or a software command that names its own start word. The request type selects a fixed entry point in the store. From that point the sequencer walks the words one per clock and presents each word's control field on `ctrl_out`.

Each word also carries three other fields: an end marker, a beat marker that raises the transfer acknowledge for that cycle, and a loop-back index. Burst patterns use the beat marker to count acknowledges against the number the configured port width needs. They keep looping back until that count is met. An exception event aborts any other running pattern and redirects the sequencer to the exception entry point.

Top module: `mem_pattern_seq`

## Requirements
- R1: A store word is `{end[15], beat[14], loop_idx[13:8], ctrl[7:0]}` and is written through `ram_we`/`ram_waddr`/`ram_wdata`. While `busy` is high, `ctrl_out` equals bits [7:0] of the word at `pat_idx`. The next cycle's `pat_idx` is `pat_idx+1` whenever the current word has no end marker.
- R2: A memory access starts at 0x00 for a single-beat read, 0x08 for a burst read, 0x18 for a single-beat write and 0x20 for a burst write. The type is chosen by `acc_write` and `acc_burst`, and `pat_kind` reads 0, 1, 2 and 3 respectively.
- R3: A refresh tick starts at 0x30 with `pat_kind` 4. An exception starts at 0x3C with `pat_kind` 5.
- R4: A software command starts at `cmd_idx`, which may be any word 0 to 63, with `pat_kind` 6.
- R5: When several requests are present while idle, the exception wins over the refresh tick, the refresh tick over the command, and the command over the memory access.
- R6: An exception seen while a non-exception pattern runs replaces it on the next cycle with word 0x3C. An exception seen while the exception pattern runs has no effect.
- R7: A single-beat access, a refresh tick and a command end at the first word with the end marker, whatever the port width.
- R8: A burst pattern reaching an end word loops to that word's `loop_idx` until it has raised 4 acknowledges with `port_size` 00 (32-bit), 8 with 01 (16-bit) or 16 with 1x (8-bit). `port_size` is sampled when the request is accepted.
- R9: `busy` rises the cycle after acceptance and falls after the finishing end word. Non-exception requests seen while `busy` is high are dropped and are not started later.
- R10: `xfer_ack` equals the beat marker of the current word while busy. While idle, `ctrl_out` and `xfer_ack` are 0, and after reset `pat_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ram_we | input | 1 | Pattern store write strobe |
| ram_waddr | input | 6 | Pattern store write index |
| ram_wdata | input | 16 | Pattern store write word |
| port_size | input | 2 | Data port width: 00 32-bit, 01 16-bit, 1x 8-bit |
| acc_req | input | 1 | Memory access request |
| acc_write | input | 1 | Access is a write |
| acc_burst | input | 1 | Access is a burst |
| tmr_req | input | 1 | Periodic refresh tick request |
| exc_req | input | 1 | Exception event |
| cmd_req | input | 1 | Software command request |
| cmd_idx | input | 6 | Start word of the software command |
| busy | output | 1 | A pattern is running |
| pat_idx | output | 6 | Index of the word presented this cycle |
| pat_kind | output | 3 | Type of the running pattern |
| ctrl_out | output | 8 | Control field of the current word |
| xfer_ack | output | 1 | Transfer acknowledge for this cycle |

## Verification
Any fault in the program counter, the entry-point choice or the beat count shows on `pat_idx` and `ctrl_out` in the very cycle the pattern should diverge. The first fault of this kind appears at the first word after acceptance, or at the end word of a burst. A wrong acknowledge target lengthens or shortens a burst by whole loop passes, so the bench sees extra or missing words before the pattern finishes. A lost preemption or a remembered held-off request leaves the sequencer busy when the expected word list is empty, which the bench catches within one cycle.

// File: rtl/mps_pkg.sv
package mps_pkg;
  localparam int IDX_W  = 6;
  localparam int CTRL_W = 8;
  localparam int WORD_W = CTRL_W + IDX_W + 2;
  localparam int CNT_W  = 5;

  typedef enum logic [2:0] {
    K_RD_ONE = 3'd0,
    K_RD_BST = 3'd1,
    K_WR_ONE = 3'd2,
    K_WR_BST = 3'd3,
    K_TICK   = 3'd4,
    K_EXC    = 3'd5,
    K_CMD    = 3'd6
  } kind_e;

  function automatic logic [IDX_W-1:0] entry_point(kind_e k);
    case (k)
      K_RD_ONE: return 6'h00;
      K_RD_BST: return 6'h08;
      K_WR_ONE: return 6'h18;
      K_WR_BST: return 6'h20;
      K_TICK:   return 6'h30;
      K_EXC:    return 6'h3C;
      default:  return 6'h00;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] acks_for(logic burst, logic [1:0] psize);
    if (!burst) return 5'd1;
    case (psize)
      2'b00:   return 5'd4;
      2'b01:   return 5'd8;
      default: return 5'd16;
    endcase
  endfunction

  function automatic logic loops_on_beats(kind_e k);
    return (k == K_RD_BST) || (k == K_WR_BST);
  endfunction
endpackage

// File: rtl/mps_pattern_ram.sv
module mps_pattern_ram #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/mps_arbiter.sv
module mps_arbiter
  import mps_pkg::*;
(
  input  logic             acc_req,
  input  logic             acc_write,
  input  logic             acc_burst,
  input  logic             tmr_req,
  input  logic             exc_req,
  input  logic             cmd_req,
  input  logic [IDX_W-1:0] cmd_idx,
  output logic             grant,
  output kind_e            grant_kind,
  output logic [IDX_W-1:0] grant_idx,
  output logic             grant_burst
);
  kind_e acc_kind;

  always_comb begin
    case ({acc_write, acc_burst})
      2'b00:   acc_kind = K_RD_ONE;
      2'b01:   acc_kind = K_RD_BST;
      2'b10:   acc_kind = K_WR_ONE;
      default: acc_kind = K_WR_BST;
    endcase
  end

  always_comb begin
    grant      = 1'b1;
    grant_kind = K_RD_ONE;
    if (exc_req)      grant_kind = K_EXC;
    else if (tmr_req) grant_kind = K_TICK;
    else if (cmd_req) grant_kind = K_CMD;
    else if (acc_req) grant_kind = acc_kind;
    else              grant      = 1'b0;
    grant_idx   = (grant_kind == K_CMD) ? cmd_idx : entry_point(grant_kind);
    grant_burst = loops_on_beats(grant_kind);
  end
endmodule

// File: rtl/mps_beat_counter.sv
module mps_beat_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] need_in,
  input  logic             inc,
  output logic [CNT_W-1:0] count,
  output logic             target_met
);
  logic [CNT_W-1:0] need_q;
  logic [CNT_W:0]   after_this;

  assign after_this = {1'b0, count} + {{CNT_W{1'b0}}, inc};
  assign target_met = after_this >= {1'b0, need_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      need_q <= '0;
    end else if (load) begin
      count  <= '0;
      need_q <= need_in;
    end else if (inc) begin
      count  <= after_this[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/mem_pattern_seq.sv
module mem_pattern_seq
  import mps_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int WW   = CTRL_W + AW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ram_we,
  input  logic [AW-1:0]     ram_waddr,
  input  logic [WW-1:0]     ram_wdata,
  input  logic [1:0]        port_size,
  input  logic              acc_req,
  input  logic              acc_write,
  input  logic              acc_burst,
  input  logic              tmr_req,
  input  logic              exc_req,
  input  logic              cmd_req,
  input  logic [AW-1:0]     cmd_idx,
  output logic              busy,
  output logic [AW-1:0]     pat_idx,
  output logic [2:0]        pat_kind,
  output logic [CTRL_W-1:0] ctrl_out,
  output logic              xfer_ack
);
  logic          busy_q;
  logic [AW-1:0] pc_q;
  kind_e         kind_q;

  logic [WW-1:0]     word;
  logic              w_last, w_beat;
  logic [AW-1:0]     w_loop;
  logic [CTRL_W-1:0] w_ctrl;

  logic          grant, grant_burst;
  kind_e         grant_kind;
  logic [AW-1:0] grant_idx;

  logic             start_now, preempt, seq_end, loop_back, beat_inc, cnt_load;
  logic [CNT_W-1:0] beat_cnt;
  logic             beats_met;

  mps_pattern_ram #(.DEPTH(DEPTH), .WIDTH(WW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (pc_q),
    .rdata (word)
  );

  assign w_last = word[WW-1];
  assign w_beat = word[WW-2];
  assign w_loop = word[WW-3 -: AW];
  assign w_ctrl = word[CTRL_W-1:0];

  mps_arbiter u_arb (
    .acc_req     (acc_req),
    .acc_write   (acc_write),
    .acc_burst   (acc_burst),
    .tmr_req     (tmr_req),
    .exc_req     (exc_req),
    .cmd_req     (cmd_req),
    .cmd_idx     (cmd_idx),
    .grant       (grant),
    .grant_kind  (grant_kind),
    .grant_idx   (grant_idx),
    .grant_burst (grant_burst)
  );

  // Named events for the checker and for readability.
  assign start_now = !busy_q && grant;
  assign preempt   = busy_q && exc_req && (kind_q != K_EXC);
  assign beat_inc  = busy_q && !preempt && w_beat;
  assign cnt_load  = start_now || preempt;
  assign seq_end   = busy_q && !preempt && w_last &&
                     (!loops_on_beats(kind_q) || beats_met);
  assign loop_back = busy_q && !preempt && w_last &&
                     loops_on_beats(kind_q) && !beats_met;

  mps_beat_counter #(.CNT_W(CNT_W)) u_beats (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (cnt_load),
    .need_in    (acks_for(start_now && grant_burst, port_size)),
    .inc        (beat_inc),
    .count      (beat_cnt),
    .target_met (beats_met)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pc_q   <= '0;
      kind_q <= K_RD_ONE;
    end else if (start_now) begin
      busy_q <= 1'b1;
      pc_q   <= grant_idx;
      kind_q <= grant_kind;
    end else if (preempt) begin
      pc_q   <= entry_point(K_EXC);
      kind_q <= K_EXC;
    end else if (seq_end) begin
      busy_q <= 1'b0;
      pc_q   <= '0;
    end else if (loop_back) begin
      pc_q   <= w_loop;
    end else if (busy_q) begin
      pc_q   <= pc_q + 1'b1;
    end
  end

  assign busy     = busy_q;
  assign pat_idx  = pc_q;
  assign pat_kind = kind_q;
  assign ctrl_out = busy_q ? w_ctrl : '0;
  assign xfer_ack = busy_q && w_beat;
endmodule

// File: rtl/mps_checker.sv
module mps_checker #(
  parameter int AW = 6,
  parameter int CW = 8,
  parameter int NW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          exc_req,
  input logic          tmr_req,
  input logic          cmd_req,
  input logic [AW-1:0] cmd_idx,
  input logic [AW-1:0] pat_idx,
  input logic [2:0]    pat_kind,
  input logic [CW-1:0] ctrl_out,
  input logic          xfer_ack,
  input logic          seq_end,
  input logic          w_last,
  input logic [NW-1:0] beat_cnt
);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ctrl_out == '0 && !xfer_ack && beat_cnt <= NW'(16)));

  // R5
  idle_exc_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && exc_req |=> busy && pat_kind == 3'd5 && pat_idx == 6'h3C);

  // R4
  cmd_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && cmd_req && !exc_req && !tmr_req |=>
      busy && pat_kind == 3'd6 && pat_idx == $past(cmd_idx));

  // R6
  preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && exc_req && pat_kind != 3'd5 |=> busy && pat_kind == 3'd5 && pat_idx == 6'h3C);

  // R9
  end_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_end |=> !busy);

  // R9
  hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !seq_end && !exc_req |=> busy && $stable(pat_kind));

  // R1
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !w_last && !exc_req |=> pat_idx == $past(pat_idx) + 6'd1);
endmodule

bind mem_pattern_seq mps_checker #(.AW(6), .CW(8), .NW(5)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .exc_req  (exc_req),
  .tmr_req  (tmr_req),
  .cmd_req  (cmd_req),
  .cmd_idx  (cmd_idx),
  .pat_idx  (pat_idx),
  .pat_kind (pat_kind),
  .ctrl_out (ctrl_out),
  .xfer_ack (xfer_ack),
  .seq_end  (seq_end),
  .w_last   (w_last),
  .beat_cnt (beat_cnt)
);

// File: tb/mem_pattern_seq_tb.sv
module mem_pattern_seq_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic ram_we = 0;
  logic [5:0] ram_waddr = 0;
  logic [15:0] ram_wdata = 0;
  logic [1:0] port_size = 0;
  logic acc_req = 0, acc_write = 0, acc_burst = 0;
  logic tmr_req = 0, exc_req = 0, cmd_req = 0;
  logic [5:0] cmd_idx = 0;
  logic busy, xfer_ack;
  logic [5:0] pat_idx;
  logic [2:0] pat_kind;
  logic [7:0] ctrl_out;

  int checks = 0;
  int errors = 0;
  bit mon_en = 0;
  logic [15:0] mem [64];
  logic [17:0] expq [$];
  string tagq [$];
  logic [17:0] exp_item;
  string exp_tag;

  always #2 clk = ~clk;

  mem_pattern_seq u_dut (
    .clk(clk), .rst_n(rst_n), .ram_we(ram_we), .ram_waddr(ram_waddr),
    .ram_wdata(ram_wdata), .port_size(port_size), .acc_req(acc_req),
    .acc_write(acc_write), .acc_burst(acc_burst), .tmr_req(tmr_req),
    .exc_req(exc_req), .cmd_req(cmd_req), .cmd_idx(cmd_idx), .busy(busy),
    .pat_idx(pat_idx), .pat_kind(pat_kind), .ctrl_out(ctrl_out), .xfer_ack(xfer_ack)
  );

  function automatic logic [15:0] mk(bit fin, bit beat, logic [5:0] lp, logic [7:0] c);
    return {fin, beat, lp, c};
  endfunction

  // Expected word trace of one pattern, built from the written store image.
  task automatic push_pat(input logic [5:0] st, input logic [2:0] kd, input bit brst,
                          input int need, input int limit, input string tag);
    int cnt = 0;
    int n = 0;
    logic [5:0] pc = st;
    logic [15:0] w;
    while (n < 300) begin
      if (limit >= 0 && n >= limit) break;
      w = mem[pc];
      expq.push_back({pc, kd, w[7:0], w[14]});
      tagq.push_back(tag);
      n++;
      if (w[14]) cnt++;
      if (w[15]) begin
        if (brst && cnt < need) pc = w[13:8];
        else break;
      end else pc = pc + 6'd1;
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(input bit a, input bit wr, input bit b, input bit t,
                       input bit x, input bit c, input logic [5:0] ci);
    acc_req = a; acc_write = wr; acc_burst = b;
    tmr_req = t; exc_req = x; cmd_req = c; cmd_idx = ci;
    @(negedge clk);
    acc_req = 0; tmr_req = 0; exc_req = 0; cmd_req = 0;
  endtask

  always @(negedge clk) begin
    if (mon_en && busy) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R9 busy with idx=%h kind=%0d, expected idle", pat_idx, pat_kind);
      end else begin
        exp_item = expq.pop_front();
        exp_tag  = tagq.pop_front();
        if ({pat_idx, pat_kind, ctrl_out, xfer_ack} !== exp_item) begin
          errors++;
          $display("FAIL %s idx/kind/ctrl/ack actual %h/%0d/%h/%b expected %h/%0d/%h/%b",
                   exp_tag, pat_idx, pat_kind, ctrl_out, xfer_ack,
                   exp_item[17:12], exp_item[11:9], exp_item[8:1], exp_item[0]);
        end
      end
    end
  end

  task automatic run_all();
    for (int i = 0; i < 64; i++) mem[i] = '0;
    mem[6'h00] = mk(1, 1, 0, 8'h10);
    mem[6'h08] = mk(0, 0, 0, 8'h20);
    mem[6'h09] = mk(1, 1, 6'h09, 8'h21);
    mem[6'h18] = mk(0, 0, 0, 8'h30);
    mem[6'h19] = mk(1, 1, 0, 8'h31);
    mem[6'h20] = mk(0, 1, 0, 8'h40);
    mem[6'h21] = mk(1, 1, 6'h20, 8'h41);
    mem[6'h30] = mk(0, 0, 0, 8'h50);
    mem[6'h31] = mk(0, 0, 0, 8'h51);
    mem[6'h32] = mk(1, 0, 0, 8'h52);
    mem[6'h3C] = mk(0, 0, 0, 8'h60);
    mem[6'h3D] = mk(1, 0, 0, 8'h61);
    mem[6'h28] = mk(0, 1, 0, 8'h70);
    mem[6'h29] = mk(1, 0, 0, 8'h71);
    mem[6'h3F] = mk(1, 1, 0, 8'h7F);

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    checks++;
    if (busy !== 0 || xfer_ack !== 0 || ctrl_out !== 0 || pat_idx !== 0) begin
      errors++;
      $display("FAIL R10 reset busy/ack/ctrl/idx actual %b/%b/%h/%h expected 0/0/00/00",
               busy, xfer_ack, ctrl_out, pat_idx);
    end
    // R1 load the store
    for (int i = 0; i < 64; i++) begin
      ram_we = 1; ram_waddr = 6'(i); ram_wdata = mem[i];
      @(negedge clk);
    end
    ram_we = 0;
    mon_en = 1;

    // R7 single-beat read on an 8-bit port still ends after one acknowledge
    port_size = 2'b10;
    push_pat(6'h00, 3'd0, 0, 1, -1, "R7");
    pulse(1, 0, 0, 0, 0, 0, 0); wait_idle();
    // R8 burst read, 32-bit port: 4 acknowledges
    port_size = 2'b00;
    push_pat(6'h08, 3'd1, 1, 4, -1, "R8");
    pulse(1, 0, 1, 0, 0, 0, 0); wait_idle();
    // R2 single-beat write
    push_pat(6'h18, 3'd2, 0, 1, -1, "R2");
    pulse(1, 1, 0, 0, 0, 0, 0); wait_idle();
    // R8 burst write, 16-bit port: 8 acknowledges
    port_size = 2'b01;
    push_pat(6'h20, 3'd3, 1, 8, -1, "R8");
    pulse(1, 1, 1, 0, 0, 0, 0); wait_idle();
    // R3 refresh tick
    push_pat(6'h30, 3'd4, 0, 1, -1, "R3");
    pulse(0, 0, 0, 1, 0, 0, 0); wait_idle();
    // R4 commands at an inner word and at the top word
    push_pat(6'h28, 3'd6, 0, 1, -1, "R4");
    pulse(0, 0, 0, 0, 0, 1, 6'h28); wait_idle();
    push_pat(6'h3F, 3'd6, 0, 1, -1, "R4");
    pulse(0, 0, 0, 0, 0, 1, 6'h3F); wait_idle();
    // R6 exception during the exception pattern is ignored
    push_pat(6'h3C, 3'd5, 0, 1, -1, "R6");
    pulse(0, 0, 0, 0, 1, 0, 0);
    pulse(0, 0, 0, 0, 1, 0, 0); wait_idle();
    // R5 priority: all four requests at once
    push_pat(6'h3C, 3'd5, 0, 1, -1, "R5");
    pulse(1, 0, 0, 1, 1, 1, 6'h28); wait_idle();
    push_pat(6'h30, 3'd4, 0, 1, -1, "R5");
    pulse(1, 0, 0, 1, 0, 1, 6'h28); wait_idle();
    push_pat(6'h28, 3'd6, 0, 1, -1, "R5");
    pulse(1, 0, 0, 0, 0, 1, 6'h28); wait_idle();
    // R6 exception preempts an 8-bit-port burst after six words
    port_size = 2'b10;
    push_pat(6'h08, 3'd1, 1, 16, 6, "R6");
    push_pat(6'h3C, 3'd5, 0, 1, -1, "R6");
    pulse(1, 0, 1, 0, 0, 0, 0);
    repeat (5) @(negedge clk);
    pulse(0, 0, 0, 0, 1, 0, 0); wait_idle();
    // R9 requests while busy are dropped, not started later
    push_pat(6'h18, 3'd2, 0, 1, -1, "R9");
    pulse(1, 1, 0, 0, 0, 0, 0);
    pulse(0, 0, 0, 1, 0, 1, 6'h28);
    repeat (6) @(negedge clk);
    wait_idle();
    // every expected word was produced
    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL R9 leftover expected words actual %0d expected 0", expq.size());
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R9 watchdog expired actual hung expected done");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule